// File: doc/BRIEF.md
# Bus Requester with Wait-State Watchdog

This block turns single commands from local logic into transfers on a two-phase peripheral bus (APB style). A command carries an address, a read/write flag, write data, byte strobes and protection bits. When the block is idle it takes the command, decodes a field of the address into a one-hot select for one of up to sixteen completers, and runs a setup cycle and then an access phase. The access phase lasts until the completer raises ready.

The block counts the access cycles in which ready stays low. If ready is still low when the limit is reached, the block drops the transfer. The response then reports a timeout, which is a status separate from the completer's own error flag. Every outcome produces one response pulse that carries read data and status. A completer error flag is taken into account only when a build parameter enables it. The watchdog can also be removed by a build parameter.

Top module: `apb_requester`

## Requirements
- R1: On acceptance, exactly one select bit rises: the bit whose index is the address field `cmdAddr[SEL_LSB +: 4]` (bits 15:12 by default). In every other idle cycle, all select bits are zero.
- R2: While reset is asserted, the select vector, enable and the response valid are all low.
- R3: In the cycle after a command is accepted, select is high and enable is low. Enable is high in the cycle after that, so the setup phase lasts exactly one cycle.
- R4: During every access cycle, enable stays high and the select vector does not change. Enable is never high while all select bits are zero.
- R5: Ready is sampled high in an access cycle. In the next cycle, select and enable are both low, and the response valid is high for exactly one cycle.
- R6: The bus address, direction, write data and protection bits keep the values of the accepted command from the setup cycle until enable falls.
- R7: For a write, the bus strobes equal the command strobes. For a read, the bus strobes are zero.
- R8: Suppose ready is low in WAIT_LIMIT consecutive access cycles. Then the transfer is dropped at the end of the last of those cycles. The next cycle has select and enable low and a response with timeout set to 1, error set to 0 and read data of zero. If ready is high in the WAIT_LIMIT-th access cycle, the transfer completes normally.
- R9: The completer error input is used only in the cycle where ready is sampled high, and it is reported on the response error. When the error is high in a wait cycle, it has no effect. When ERR_EN is 0, the response error is always 0.
- R10: Command ready is high only in the idle state. A command offered while a transfer is running is not taken: the bus address keeps the running transfer's value, and no extra response is produced.
- R11: A completed read returns the bus read data sampled in its final cycle. A completed write returns zero read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | A command is offered |
| cmdReady | output | 1 | The block is idle and takes the command |
| cmdAddr | input | ADDR_W | Command address |
| cmdWrite | input | 1 | 1 for write, 0 for read |
| cmdWdata | input | DATA_W | Write data |
| cmdStrb | input | DATA_W/8 | Byte strobes for a write |
| cmdProt | input | 3 | Protection bits |
| rspValid | output | 1 | One-cycle response pulse |
| rspRdata | output | DATA_W | Read data, zero for writes and timeouts |
| rspErr | output | 1 | Completer reported an error |
| rspTimeout | output | 1 | Transfer dropped by the watchdog |
| busSel | output | NUM_TGT | One-hot completer select |
| busEnable | output | 1 | Access phase enable |
| busAddr | output | ADDR_W | Bus address |
| busWrite | output | 1 | Bus direction |
| busWdata | output | DATA_W | Bus write data |
| busStrb | output | DATA_W/8 | Bus byte strobes |
| busProt | output | 3 | Bus protection bits |
| busReady | input | 1 | Completer ready |
| busRdata | input | DATA_W | Completer read data |
| busSlvErr | input | 1 | Completer error |

## Verification
The normal completion and the watchdog abort can meet in one cycle: the WAIT_LIMIT-th access cycle. In that cycle the counter has reached its limit just as the completer raises ready. The bench provokes this with a wait of exactly WAIT_LIMIT-1 low cycles, which must give a normal response with no timeout. A wait of WAIT_LIMIT low cycles must give a timeout with zero data. Random waits across the whole range, together with a noisy error input during wait cycles, exercise the cases on either side of that boundary.

// File: rtl/apb_req_pkg.sv
package apb_req_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture command, raise select
    logic finish;  // ready seen in access phase
    logic abort;   // wait limit reached
  } dp_ctl_t;

endpackage

// File: rtl/apb_req_ctrl.sv
module apb_req_ctrl
  import apb_req_pkg::*;
#(
  parameter int WAIT_LIMIT = 100,
  parameter bit WDOG_EN    = 1'b1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdValid,
  input  logic    busReady,
  output logic    cmdReady,
  output logic    busEnable,
  output dp_ctl_t dpCtl
);

  localparam int CNT_W = $clog2(WAIT_LIMIT + 1);

  phase_e           state;
  phase_e           stateNext;
  logic [CNT_W-1:0] waitCnt;
  logic             abortHit;

  assign cmdReady  = (state == PH_IDLE);
  assign busEnable = (state == PH_ACCESS);

  generate
    if (WDOG_EN) begin : g_wdog
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          waitCnt <= '0;
        else if (state != PH_ACCESS || busReady || abortHit)
          waitCnt <= '0;
        else
          waitCnt <= waitCnt + 1'b1;
      end
      assign abortHit = (state == PH_ACCESS) && !busReady &&
                        (waitCnt == CNT_W'(WAIT_LIMIT - 1));

      // R8: the counter never passes the limit inside an access phase
      a_r8_wait_bounded: assert property (@(posedge clk) disable iff (!rstN)
        (state == PH_ACCESS) |-> (waitCnt < CNT_W'(WAIT_LIMIT)));
    end else begin : g_nowdog
      assign waitCnt  = '0;
      assign abortHit = 1'b0;
    end
  endgenerate

  always_comb begin
    dpCtl.load   = (state == PH_IDLE) && cmdValid;
    dpCtl.finish = (state == PH_ACCESS) && busReady;
    dpCtl.abort  = abortHit;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      PH_IDLE:   if (cmdValid) stateNext = PH_SETUP;
      PH_SETUP:  stateNext = PH_ACCESS;
      PH_ACCESS: if (busReady || abortHit) stateNext = PH_IDLE;
      default:   stateNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PH_IDLE;
    else       state <= stateNext;
  end

  // R10: a new command is only taken from idle
  a_r10_load_idle_only: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.load |=> (state == PH_SETUP));

endmodule

// File: rtl/apb_req_dp.sv
module apb_req_dp
  import apb_req_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int NUM_TGT = 16,
  parameter int SEL_LSB = 12,
  parameter bit ERR_EN  = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dp_ctl_t               dpCtl,
  input  logic [ADDR_W-1:0]     cmdAddr,
  input  logic                  cmdWrite,
  input  logic [DATA_W-1:0]     cmdWdata,
  input  logic [DATA_W/8-1:0]   cmdStrb,
  input  logic [2:0]            cmdProt,
  input  logic [DATA_W-1:0]     busRdata,
  input  logic                  busSlvErr,
  output logic [NUM_TGT-1:0]    busSel,
  output logic [ADDR_W-1:0]     busAddr,
  output logic                  busWrite,
  output logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W/8-1:0]   busStrb,
  output logic [2:0]            busProt,
  output logic                  rspValid,
  output logic [DATA_W-1:0]     rspRdata,
  output logic                  rspErr,
  output logic                  rspTimeout
);

  localparam int SEL_W  = $clog2(NUM_TGT);
  localparam int STRB_W = DATA_W / 8;

  logic [SEL_W-1:0]   tgtIdx;
  logic [NUM_TGT-1:0] decSel;
  logic               errSample;

  assign tgtIdx = cmdAddr[SEL_LSB +: SEL_W];

  generate
    for (genvar i = 0; i < NUM_TGT; i++) begin : g_dec
      assign decSel[i] = (tgtIdx == SEL_W'(i));
    end
    if (ERR_EN) begin : g_err
      assign errSample = busSlvErr;
    end else begin : g_noerr
      assign errSample = 1'b0;
    end
  endgenerate

  // bus side command registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busSel   <= '0;
      busAddr  <= '0;
      busWrite <= 1'b0;
      busWdata <= '0;
      busStrb  <= '0;
      busProt  <= '0;
    end else if (dpCtl.load) begin
      busSel   <= decSel;
      busAddr  <= cmdAddr;
      busWrite <= cmdWrite;
      busWdata <= cmdWdata;
      busStrb  <= cmdWrite ? cmdStrb : STRB_W'(0);
      busProt  <= cmdProt;
    end else if (dpCtl.finish || dpCtl.abort) begin
      busSel   <= '0;
    end
  end

  // response registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspRdata   <= '0;
      rspErr     <= 1'b0;
      rspTimeout <= 1'b0;
    end else begin
      rspValid <= dpCtl.finish || dpCtl.abort;
      if (dpCtl.finish || dpCtl.abort) begin
        rspRdata   <= (dpCtl.finish && !busWrite) ? busRdata : '0;
        rspErr     <= dpCtl.finish && errSample;
        rspTimeout <= dpCtl.abort;
      end
    end
  end

  // R7: reads never carry strobes on the bus
  a_r7_read_strb_zero: assert property (@(posedge clk) disable iff (!rstN)
    ((|busSel) && !busWrite) |-> (busStrb == '0));

  // R8: a timeout never reports data or a completer error
  a_r8_timeout_clean: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspTimeout) |-> (!rspErr && rspRdata == '0));

endmodule

// File: rtl/apb_requester.sv
module apb_requester
  import apb_req_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int NUM_TGT    = 16,
  parameter int SEL_LSB    = 12,
  parameter int WAIT_LIMIT = 100,
  parameter bit WDOG_EN    = 1'b1,
  parameter bit ERR_EN     = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cmdValid,
  output logic                  cmdReady,
  input  logic [ADDR_W-1:0]     cmdAddr,
  input  logic                  cmdWrite,
  input  logic [DATA_W-1:0]     cmdWdata,
  input  logic [DATA_W/8-1:0]   cmdStrb,
  input  logic [2:0]            cmdProt,
  output logic                  rspValid,
  output logic [DATA_W-1:0]     rspRdata,
  output logic                  rspErr,
  output logic                  rspTimeout,
  output logic [NUM_TGT-1:0]    busSel,
  output logic                  busEnable,
  output logic [ADDR_W-1:0]     busAddr,
  output logic                  busWrite,
  output logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W/8-1:0]   busStrb,
  output logic [2:0]            busProt,
  input  logic                  busReady,
  input  logic [DATA_W-1:0]     busRdata,
  input  logic                  busSlvErr
);

  dp_ctl_t dpCtl;

  apb_req_ctrl #(
    .WAIT_LIMIT (WAIT_LIMIT),
    .WDOG_EN    (WDOG_EN)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .busReady  (busReady),
    .cmdReady  (cmdReady),
    .busEnable (busEnable),
    .dpCtl     (dpCtl)
  );

  apb_req_dp #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .NUM_TGT (NUM_TGT),
    .SEL_LSB (SEL_LSB),
    .ERR_EN  (ERR_EN)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .dpCtl      (dpCtl),
    .cmdAddr    (cmdAddr),
    .cmdWrite   (cmdWrite),
    .cmdWdata   (cmdWdata),
    .cmdStrb    (cmdStrb),
    .cmdProt    (cmdProt),
    .busRdata   (busRdata),
    .busSlvErr  (busSlvErr),
    .busSel     (busSel),
    .busAddr    (busAddr),
    .busWrite   (busWrite),
    .busWdata   (busWdata),
    .busStrb    (busStrb),
    .busProt    (busProt),
    .rspValid   (rspValid),
    .rspRdata   (rspRdata),
    .rspErr     (rspErr),
    .rspTimeout (rspTimeout)
  );

  // R1: select is one-hot or idle and never unknown
  a_r1_sel_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(busSel) && !$isunknown(busSel));

  // R3: setup lasts exactly one cycle
  a_r3_setup_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    ((|busSel) && !busEnable) |=> busEnable);

  // R4: select frozen while enable is high, enable needs select
  a_r4_sel_stable: assert property (@(posedge clk) disable iff (!rstN)
    busEnable |-> $stable(busSel));
  a_r4_enable_needs_sel: assert property (@(posedge clk) disable iff (!rstN)
    !(|busSel) |-> !busEnable);

  // R5: ready in access ends the transfer on the next cycle
  a_r5_end_after_ready: assert property (@(posedge clk) disable iff (!rstN)
    (busEnable && busReady) |=> (!busEnable && !(|busSel) && rspValid));
  a_r5_rsp_single: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R6: bus fields held through the access phase
  a_r6_fields_hold: assert property (@(posedge clk) disable iff (!rstN)
    busEnable |-> ($stable(busAddr) && $stable(busWrite) && $stable(busWdata) &&
                   $stable(busStrb) && $stable(busProt)));

endmodule

// File: tb/tb_apb_requester.sv
module tb_apb_requester;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [31:0] cmdAddr = '0;
  logic        cmdWrite = 1'b0;
  logic [31:0] cmdWdata = '0;
  logic [3:0]  cmdStrb = '0;
  logic [2:0]  cmdProt = '0;
  logic        busReady = 1'b0;
  logic [31:0] busRdata = '0;
  logic        busSlvErr = 1'b0;

  logic        cmdReady, rspValid, rspErr, rspTimeout, busEnable, busWrite;
  logic [31:0] rspRdata, busAddr, busWdata;
  logic [15:0] busSel;
  logic [3:0]  busStrb;
  logic [2:0]  busProt;

  logic        q_cmdReady, q_rspValid, q_rspErr, q_rspTimeout, q_busEnable, q_busWrite;
  logic [31:0] q_rspRdata, q_busAddr, q_busWdata;
  logic [15:0] q_busSel;
  logic [3:0]  q_busStrb;
  logic [2:0]  q_busProt;

  int nChecks = 0;
  int nFail   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  apb_requester #(.WAIT_LIMIT(LIMIT)) dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdAddr(cmdAddr), .cmdWrite(cmdWrite), .cmdWdata(cmdWdata),
    .cmdStrb(cmdStrb), .cmdProt(cmdProt), .rspValid(rspValid),
    .rspRdata(rspRdata), .rspErr(rspErr), .rspTimeout(rspTimeout),
    .busSel(busSel), .busEnable(busEnable), .busAddr(busAddr),
    .busWrite(busWrite), .busWdata(busWdata), .busStrb(busStrb),
    .busProt(busProt), .busReady(busReady), .busRdata(busRdata),
    .busSlvErr(busSlvErr));

  apb_requester #(.WAIT_LIMIT(LIMIT), .ERR_EN(1'b0)) dutNoErr (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(q_cmdReady),
    .cmdAddr(cmdAddr), .cmdWrite(cmdWrite), .cmdWdata(cmdWdata),
    .cmdStrb(cmdStrb), .cmdProt(cmdProt), .rspValid(q_rspValid),
    .rspRdata(q_rspRdata), .rspErr(q_rspErr), .rspTimeout(q_rspTimeout),
    .busSel(q_busSel), .busEnable(q_busEnable), .busAddr(q_busAddr),
    .busWrite(q_busWrite), .busWdata(q_busWdata), .busStrb(q_busStrb),
    .busProt(q_busProt), .busReady(busReady), .busRdata(busRdata),
    .busSlvErr(busSlvErr));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] expSel(input logic [31:0] a);
    return 16'(1) << a[15:12];
  endfunction

  function automatic logic [31:0] expRdata(input bit tmo, input logic w, input logic [31:0] rd);
    return (tmo || w) ? 32'h0 : rd;
  endfunction

  task automatic runTxn(input logic [31:0] a, input logic w, input logic [31:0] wd,
                        input logic [3:0] st, input logic [2:0] pr, input int waits,
                        input logic err, input logic [31:0] rd);
    int  n;
    bit  done;
    bit  tmo;
    @(negedge clk);
    cmdAddr = a; cmdWrite = w; cmdWdata = wd; cmdStrb = st; cmdProt = pr;
    cmdValid = 1'b1;
    chk("R10 ready when idle", cmdReady, 1);
    @(negedge clk);
    cmdValid = 1'b0;
    chk("R1 select decode", busSel, expSel(a));
    chk("R3 setup enable low", busEnable, 0);
    chk("R7 strobes", busStrb, w ? st : 4'h0);
    chk("R6 address", busAddr, a);
    chk("R6 direction", busWrite, w);
    chk("R6 wdata", busWdata, wd);
    chk("R6 prot", busProt, pr);
    n = 0; done = 0; tmo = 0;
    while (!done) begin
      @(negedge clk);
      n++;
      chk(n == 1 ? "R3 enable after setup" : "R4 enable held", busEnable, 1);
      chk("R4 select held", busSel, expSel(a));
      chk("R6 address held", busAddr, a);
      chk("R6 wdata held", busWdata, wd);
      chk("R10 busy not ready", cmdReady, 0);
      if (n > waits) begin
        busReady = 1'b1; busSlvErr = err; busRdata = rd;
        cmdValid = 1'b0; done = 1;
      end else begin
        busReady = 1'b0;
        busSlvErr = 1'($urandom % 2);
        busRdata = $urandom;
        cmdValid = 1'($urandom % 2);
        cmdAddr = $urandom;
        if (n == LIMIT) begin
          done = 1; tmo = 1; cmdValid = 1'b0;
        end
      end
    end
    @(negedge clk);
    busReady = 1'b0; busSlvErr = 1'b0; cmdAddr = a;
    chk("R5 response valid", rspValid, 1);
    chk(tmo ? "R8 select dropped" : "R5 select dropped", busSel, 16'h0);
    chk(tmo ? "R8 enable dropped" : "R5 enable dropped", busEnable, 0);
    chk("R8 timeout flag", rspTimeout, tmo);
    chk("R9 error flag", rspErr, !tmo && err);
    chk("R9 error disabled", q_rspErr, 0);
    chk("R11 read data", rspRdata, expRdata(tmo, w, rd));
    chk("R10 busy command ignored", busAddr, a);
    @(negedge clk);
    chk("R5 response single pulse", rspValid, 0);
    chk("R10 no extra transfer", busSel, 16'h0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk("R2 select in reset", busSel, 16'h0);
    chk("R2 enable in reset", busEnable, 0);
    chk("R2 valid in reset", rspValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle select", busSel, 16'h0);

    for (int t = 0; t < 16; t++)
      runTxn({16'h0, 4'(t), 12'h0}, 1'b0, 32'h0, 4'hF, 3'(t), 0, 1'b0, 32'hA000_0000 + t);
    // ready in the very cycle the limit is reached: normal completion
    runTxn(32'h0000_3010, 1'b0, 32'h0, 4'h0, 3'd1, LIMIT - 1, 1'b0, 32'hCAFE_F00D);
    runTxn(32'h0000_5020, 1'b1, 32'h1234_5678, 4'h5, 3'd2, LIMIT - 1, 1'b1, 32'h0);
    // ready never arrives in time: timeout
    runTxn(32'h0000_7030, 1'b0, 32'h0, 4'hF, 3'd3, LIMIT, 1'b1, 32'hDEAD_BEEF);
    runTxn(32'h0000_9040, 1'b1, 32'h8765_4321, 4'hA, 3'd4, LIMIT + 5, 1'b0, 32'h0);
    // completer error on read with waits
    runTxn(32'h0000_B050, 1'b0, 32'h0, 4'h3, 3'd5, 3, 1'b1, 32'h1111_2222);

    for (int k = 0; k < 60; k++)
      runTxn($urandom, 1'($urandom % 2), $urandom, 4'($urandom), 3'($urandom),
             int'($urandom % (LIMIT + 2)), 1'($urandom % 4 == 0), $urandom);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule